// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the time base for a pulse-width modulator. A counter of parameterised width (16 bits by default) advances once per prescaled tick. The tick comes from a two-stage divider whose settings sit in a control register. That register also selects the counting direction, the run/stop policy and how period writes take effect. The block publishes the counter value and two single-cycle strobes. One marks the counter landing on zero and the other marks it landing on the active period. A downstream output-action stage uses them to set, clear or toggle waveform pins.

Software programs the block through a plain register-write port made of write enable, address and 16-bit data. No stream of data passes through the block, so it has no valid/ready handshake and nothing can apply back-pressure. A write is taken on every clock edge where the write enable is high. The counter, the strobes and the outputs carrying configuration are plain level signals. They change only on rising clock edges.

Top module: `pwm_timebase`

## Requirements
- R1: After the asynchronous active-low reset the counter reads 0 and both strobes are low. The control word is all zero: up mode, stopped, shadowed period load, divide by 1. Both the active and the shadow period hold the `RST_PRD` parameter.
- R2: A write to address 0 loads the control word and a write to address 1 loads the period (its low `CNT_W` bits). Writes to any other address change nothing. Control fields: bits [1:0] are the mode, bit 3 is the period-load select, bits [9:7] are the fast prescaler, bits [12:10] are the slow prescaler and bits [15:14] are the run policy.
- R3: Mode 00 counts up. From a value below the active period P it steps by one. When it reaches or passes P, the next step goes to 0.
- R4: Mode 01 counts down. From a nonzero value it steps down by one. From 0 it reloads P.
- R5: Mode 10 counts up and down. While rising it reverses at P, so the step taken from P goes to P-1. While falling it reverses at 0, so the step taken from 0 goes to 1, or stays at 0 when P is 0.
- R6: Mode 11 freezes the counter. Ticks then change neither the value nor the strobes.
- R7: Run policy 00 stops the counter: from the first tick after the control word takes effect, the value holds and no strobe fires.
- R8: Run policy 01 lets the current cycle finish. The counter keeps advancing while it is nonzero, then holds at 0.
- R9: Run policy 10 or 11 runs freely. Counting resumes from whatever value was held, in whatever direction was last used.
- R10: The tick interval in clocks is F × 2^S. S is the slow field. F is 1 when the fast field h is 0, and 2h otherwise. The largest interval is 14 × 128 = 1792 clocks.
- R11: When bit 3 is 1, a period write updates the active and the shadow copies at once. When bit 3 is 0, the write goes to the shadow copy only. The shadow copy moves into the active copy on the step that lands the counter on 0.
- R12: The zero strobe and the period strobe are high for one clock after each step that lands on 0 or on the active period respectively, and never otherwise. Both fire together when P is 0. The period strobe compares against the period in force before that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register address (0 control, 1 period) |
| wr_data | input | 16 | Register write data |
| tb_count | output | CNT_W | Current counter value |
| evt_zero | output | 1 | Counter landed on zero (one clock) |
| evt_period | output | 1 | Counter landed on the active period (one clock) |

## Verification
The bench builds the block with an 8-bit counter, a 2-bit address and a reset period of 0xFF. An 8-bit counter brings the full-scale period and its wrap within a few hundred cycles. The 2-bit address leaves two unused addresses that must be ignored. With these values, both ends of the period range fit in a short run alongside the maximum 1792-clock prescale interval. The period-zero case, where both strobes fire on every tick, is also reached.

// File: rtl/pwm_tbase_pkg.sv
`timescale 1ns/1ps
package pwm_tbase_pkg;

  localparam int CTL_W   = 16;
  localparam int PS_FW   = 3;   // fast prescaler field width
  localparam int PS_SW   = 3;   // slow prescaler field width

  // bit positions decoded by the write port
  localparam int MODE_LSB = 0;
  localparam int IMM_BIT  = 3;
  localparam int FAST_LSB = 7;
  localparam int SLOW_LSB = 10;
  localparam int RUN_LSB  = 14;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_HOLD = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic [1:0]       run;
    logic [PS_SW-1:0] ps_slow;
    logic [PS_FW-1:0] ps_fast;
    logic             prd_imm;
    cnt_mode_e        mode;
  } ctl_t;

endpackage

// File: rtl/pwm_tbase_regs.sv
`timescale 1ns/1ps
module pwm_tbase_regs
  import pwm_tbase_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CTL_W-1:0]    wr_data,
  output ctl_t                ctl,
  output logic                prd_wr
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PRD_ADDR = ADDR_W'(1);

  logic ctl_wr;
  assign ctl_wr = wr_en && (wr_addr == CTL_ADDR);
  assign prd_wr = wr_en && (wr_addr == PRD_ADDR);

  // reserved control bits are dropped
  logic unused_ctl_bits;
  assign unused_ctl_bits = ^{wr_data[13], wr_data[6:4], wr_data[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (ctl_wr) begin
      ctl.run     <= wr_data[RUN_LSB +: 2];
      ctl.ps_slow <= wr_data[SLOW_LSB +: PS_SW];
      ctl.ps_fast <= wr_data[FAST_LSB +: PS_FW];
      ctl.prd_imm <= wr_data[IMM_BIT];
      ctl.mode    <= cnt_mode_e'(wr_data[MODE_LSB +: 2]);
    end
  end

endmodule

// File: rtl/pwm_tbase_prescale.sv
`timescale 1ns/1ps
module pwm_tbase_prescale
  import pwm_tbase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PS_FW-1:0] fast_sel,
  input  logic [PS_SW-1:0] slow_sel,
  output logic             tick
);

  localparam int FAST_DW = PS_FW + 1;                   // holds 2*h
  localparam int PS_W    = FAST_DW + (2**PS_SW) - 1;    // holds F * 2^S
  localparam logic [PS_W-1:0] PS_ONE = PS_W'(1);

  logic [FAST_DW-1:0] fast_div;
  logic [PS_W-1:0]    div_total;
  logic [PS_W-1:0]    ps_cnt;

  assign fast_div  = (fast_sel == '0) ? FAST_DW'(1) : {fast_sel, 1'b0};
  assign div_total = {{(PS_W-FAST_DW){1'b0}}, fast_div} << slow_sel;

  // ">=" so that shrinking the divide mid-interval still closes it
  assign tick = (ps_cnt >= (div_total - PS_ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ps_cnt <= '0;
    else if (tick) ps_cnt <= '0;
    else           ps_cnt <= ps_cnt + PS_ONE;
  end

endmodule

// File: rtl/pwm_tbase_period.sv
`timescale 1ns/1ps
module pwm_tbase_period
  import pwm_tbase_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_PRD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_wr,
  input  logic             prd_imm,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             zero_load,
  output logic [CNT_W-1:0] prd_act
);

  logic [CNT_W-1:0] prd_shd;
  logic [CNT_W-1:0] wr_val;

  assign wr_val = wr_data[CNT_W-1:0];

  generate
    if (CNT_W < CTL_W) begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^wr_data[CTL_W-1:CNT_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_act <= RST_PRD;
      prd_shd <= RST_PRD;
    end else if (prd_wr && prd_imm) begin
      prd_act <= wr_val;
      prd_shd <= wr_val;
    end else begin
      if (zero_load) prd_act <= prd_shd;
      if (prd_wr)    prd_shd <= wr_val;
    end
  end

endmodule

// File: rtl/pwm_tbase_core.sv
`timescale 1ns/1ps
module pwm_tbase_core
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [1:0]       run,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             evt_zero,
  output logic             evt_prd,
  output logic             zero_load
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dir_up, dir_nxt;
  logic [CNT_W-1:0] nxt;
  logic             run_ok, advance;

  assign run_ok    = run[1] || ((run == 2'b01) && (cnt != '0));
  assign advance   = tick && (mode != CM_HOLD) && run_ok;
  assign zero_load = advance && (nxt == '0);

  always_comb begin
    nxt     = cnt;
    dir_nxt = dir_up;
    unique case (mode)
      CM_UP: begin
        dir_nxt = 1'b1;
        nxt     = (cnt >= prd) ? '0 : cnt + ONE;
      end
      CM_DOWN: begin
        dir_nxt = 1'b0;
        nxt     = (cnt == '0) ? prd : cnt - ONE;
      end
      CM_UPDN: begin
        if (dir_up) begin
          if (cnt >= prd) begin
            dir_nxt = 1'b0;
            nxt     = (cnt == '0) ? '0 : cnt - ONE;
          end else begin
            nxt = cnt + ONE;
          end
        end else begin
          if (cnt == '0) begin
            dir_nxt = 1'b1;
            nxt     = (prd == '0) ? '0 : ONE;
          end else begin
            nxt = cnt - ONE;
          end
        end
      end
      default: begin
        nxt     = cnt;
        dir_nxt = dir_up;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_up   <= 1'b1;
      evt_zero <= 1'b0;
      evt_prd  <= 1'b0;
    end else begin
      evt_zero <= advance && (nxt == '0);
      evt_prd  <= advance && (nxt == prd);
      if (advance) begin
        cnt    <= nxt;
        dir_up <= dir_nxt;
      end
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_tbase_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter int               ADDR_W  = 2,
  parameter logic [CNT_W-1:0] RST_PRD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic [CNT_W-1:0]  tb_count,
  output logic              evt_zero,
  output logic              evt_period
);

  ctl_t             ctl;
  cnt_mode_e        cur_mode;
  logic [1:0]       run_ctl;
  logic             prd_wr;
  logic             ps_tick;
  logic             zero_load;
  logic [CNT_W-1:0] prd_act;

  assign cur_mode = ctl.mode;
  assign run_ctl  = ctl.run;

  pwm_tbase_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctl     (ctl),
    .prd_wr  (prd_wr)
  );

  pwm_tbase_prescale u_ps (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_sel (ctl.ps_fast),
    .slow_sel (ctl.ps_slow),
    .tick     (ps_tick)
  );

  pwm_tbase_period #(.CNT_W(CNT_W), .RST_PRD(RST_PRD)) u_prd (
    .clk       (clk),
    .rst_n     (rst_n),
    .prd_wr    (prd_wr),
    .prd_imm   (ctl.prd_imm),
    .wr_data   (wr_data),
    .zero_load (zero_load),
    .prd_act   (prd_act)
  );

  pwm_tbase_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (ps_tick),
    .mode      (cur_mode),
    .run       (run_ctl),
    .prd       (prd_act),
    .cnt       (tb_count),
    .evt_zero  (evt_zero),
    .evt_prd   (evt_period),
    .zero_load (zero_load)
  );

endmodule

// File: rtl/pwm_timebase_chk.sv
`timescale 1ns/1ps
module pwm_timebase_chk
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd,
  input logic             ev_z,
  input logic             ev_p,
  input logic             tick,
  input cnt_mode_e        mode,
  input logic [1:0]       run
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  // R12
  zero_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_z |-> (cnt == '0));

  // R12
  period_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_p |-> (cnt == $past(prd)));

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_HOLD) |=> ($stable(cnt) && !ev_z && !ev_p));

  // R7
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run == 2'b00) |=> ($stable(cnt) && !ev_z && !ev_p));

  // R8
  cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((run == 2'b01) && (cnt == '0)) |=> $stable(cnt));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == CM_UP) && run[1] && tick && (cnt < prd)) |=> (cnt == $past(cnt) + STEP));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_tb_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .cnt  (tb_count),
  .prd  (prd_act),
  .ev_z (evt_zero),
  .ev_p (evt_period),
  .tick (ps_tick),
  .mode (cur_mode),
  .run  (run_ctl)
);

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;

  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         we    = 1'b0;
  logic [1:0]   addr  = '0;
  logic [15:0]  wdata = '0;
  logic [W-1:0] cnt;
  logic         evz, evp;

  pwm_timebase #(.CNT_W(W), .ADDR_W(2), .RST_PRD(8'hFF)) i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_addr(addr), .wr_data(wdata),
    .tb_count(cnt), .evt_zero(evz), .evt_period(evp)
  );

  typedef struct {
    logic [W-1:0] c;
    bit           z;
    bit           p;
    int           gap;
    string        tag;
  } exp_t;

  exp_t   q[$];
  int     n_chk  = 0;
  int     n_fail = 0;
  bit     mon_on = 1'b0;
  bit     done   = 1'b0;
  int     gap    = 0;
  logic [W-1:0] prev;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int c, input bit z, input bit p, input int g,
                      input string tag);
    exp_t e;
    e.c = W'(c); e.z = z; e.p = p; e.gap = g; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wait_q(input int n);
    while (q.size() > n) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
    end
    #1;
  endtask

  // monitor: every advance is visible as a value change or a strobe
  initial begin
    forever begin
      @(negedge clk);
      if (!mon_on) begin
        prev = cnt;
        gap  = 0;
      end else begin
        gap++;
        if ((cnt != prev) || evz || evp) begin
          if (q.size() == 0) begin
            chk(1'b0, "R12", "unexpected step, count", int'(cnt), int'(prev));
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(cnt == e.c, e.tag, "count", int'(cnt), int'(e.c));
            chk(evz == e.z, e.tag, "zero strobe", int'(evz), int'(e.z));
            chk(evp == e.p, e.tag, "period strobe", int'(evp), int'(e.p));
            if (e.gap != 0) chk(gap == e.gap, e.tag, "tick gap", gap, e.gap);
          end
          gap  = 0;
          prev = cnt;
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, pending=%0d expected=0", q.size());
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    chk(cnt == '0, "R1", "reset count", int'(cnt), 0);
    chk(!evz && !evp, "R1", "reset strobes", int'({evz, evp}), 0);
    rst_n = 1'b1;
    idle(3);
    chk(cnt == '0, "R1", "count stays 0 while stopped", int'(cnt), 0);
    mon_on = 1'b1;

    // R3 up mode, immediate period 3 (R11 immediate path, R2 decode)
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'd3);
    for (int k = 0; k < 2; k++) begin
      push(1, 0, 0, (k == 0) ? 0 : 1, "R3");
      push(2, 0, 0, 1, "R3");
      push(3, 0, 1, 1, "R3");
      push(0, 1, 0, 1, "R3");
    end
    wr(2'd0, 16'h8008);
    wait_q(1);
    wr(2'd0, 16'h0008);
    idle(5);
    // R7 stopped: value held
    chk(cnt == 8'd0, "R7", "held after stop", int'(cnt), 0);

    // R4 down mode from held 0
    wr(2'd0, 16'h0009);
    push(3, 0, 1, 0, "R4");
    push(2, 0, 0, 1, "R4");
    push(1, 0, 0, 1, "R4");
    push(0, 1, 0, 1, "R4");
    push(3, 0, 1, 1, "R4");
    push(2, 0, 0, 1, "R4");
    wr(2'd0, 16'h8009);
    wait_q(1);
    wr(2'd0, 16'h0009);
    idle(4);
    chk(cnt == 8'd2, "R7", "held after down stop", int'(cnt), 2);

    // R5 up-down, R9 resumes from held 2 going down
    wr(2'd0, 16'h000A);
    push(1, 0, 0, 0, "R9");
    push(0, 1, 0, 1, "R5");
    push(1, 0, 0, 1, "R5");
    push(2, 0, 0, 1, "R5");
    push(3, 0, 1, 1, "R5");
    push(2, 0, 0, 1, "R5");
    push(1, 0, 0, 1, "R5");
    push(0, 1, 0, 1, "R5");
    push(1, 0, 0, 1, "R5");
    wr(2'd0, 16'h800A);
    wait_q(1);
    wr(2'd0, 16'h000A);
    idle(3);

    // R6 freeze while free-running: nothing moves
    wr(2'd0, 16'h800B);
    idle(8);
    chk(cnt == 8'd1, "R6", "frozen count", int'(cnt), 1);
    chk(!evz && !evp, "R6", "frozen strobes", int'({evz, evp}), 0);

    // R8 finish cycle then hold at 0
    push(2, 0, 0, 0, "R8");
    push(3, 0, 1, 1, "R8");
    push(0, 1, 0, 1, "R8");
    wr(2'd0, 16'h4008);
    idle(10);
    chk(cnt == 8'd0, "R8", "held at zero", int'(cnt), 0);
    chk(q.size() == 0, "R8", "pending steps", q.size(), 0);

    // R11 shadow load: period 5 takes effect after next zero
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd5);
    push(1, 0, 0, 0, "R11");
    push(2, 0, 0, 1, "R11");
    push(3, 0, 1, 1, "R11");
    push(0, 1, 0, 1, "R11");
    push(1, 0, 0, 1, "R11");
    push(2, 0, 0, 1, "R11");
    push(3, 0, 0, 1, "R11");
    push(4, 0, 0, 1, "R11");
    push(5, 0, 1, 1, "R11");
    push(0, 1, 0, 1, "R11");
    wr(2'd0, 16'h8000);
    wait_q(1);
    wr(2'd0, 16'h0000);
    idle(3);

    // R2 unused addresses ignored (would start down counting if decoded)
    wr(2'd2, 16'h8009);
    wr(2'd3, 16'h8009);
    idle(6);
    chk(cnt == 8'd0, "R2", "count after stray writes", int'(cnt), 0);

    // R10 prescale: fast 3 (x6), slow 1 (x2) -> 12 clocks
    push(1, 0, 0, 0, "R10");
    push(2, 0, 0, 12, "R10");
    push(3, 0, 0, 12, "R10");
    push(4, 0, 0, 12, "R10");
    wr(2'd0, 16'h8588);
    wait_q(0);
    wr(2'd0, 16'h0588);
    // R10 fast 0 (x1), slow 2 (x4) -> 4 clocks
    push(5, 0, 1, 0, "R10");
    push(0, 1, 0, 4, "R10");
    push(1, 0, 0, 4, "R10");
    wr(2'd0, 16'h8808);
    wait_q(0);
    wr(2'd0, 16'h0808);
    // R10 largest divide 14*128
    push(2, 0, 0, 0, "R10");
    push(3, 0, 0, 1792, "R10");
    wr(2'd0, 16'h9F88);
    wait_q(0);
    wr(2'd0, 16'h1F88);
    idle(3);
    chk(cnt == 8'd3, "R10", "count after prescaled run", int'(cnt), 3);

    // R3 full-scale period and wrap
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'h00FF);
    for (int v = 4; v <= 255; v++) push(v, 0, v == 255, (v == 4) ? 0 : 1, "R3");
    push(0, 1, 0, 1, "R3");
    wr(2'd0, 16'h8008);
    wait_q(1);
    wr(2'd0, 16'h0008);
    idle(3);

    // R12 period 0: both strobes every tick
    wr(2'd1, 16'd0);
    push(0, 1, 1, 0, "R12");
    push(0, 1, 1, 1, "R12");
    push(0, 1, 1, 1, "R12");
    wr(2'd0, 16'h8008);
    wait_q(1);
    wr(2'd0, 16'h0008);
    idle(5);
    chk(q.size() == 0, "R12", "pending steps at end", q.size(), 0);
    chk(!evz && !evp, "R7", "strobes quiet when stopped", int'({evz, evp}), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule